// File: doc/BRIEF.md
# Operating-State Sequencer for a Serial-Bus Master

This block holds the operating state of a serial-bus master core and sits on a small register bus. Software requests one of three states: reset, run or pause. Once a request is accepted, the state register reports "not valid" for a fixed handshake latency. After that latency the new state takes effect and the valid flag returns. While the core is in pause, the protocol engine is held off, so software can refill its transmit queue without the engine draining it.

The block also contains:
- a software-reset strobe;
- a "master ready" indication;
- a bank of write-one-to-clear operational event flags (service requests and count-done);
- a masked error-flag bank;
- a bus-error latch;
- a level-high interrupt output.

The protocol engine and the FIFOs are not part of this block. They appear only as stub inputs: event pulses, error pulses, a bus-error pulse and an idle indication.

Top module: `bus_state_ctrl`

## Requirements
- R1: After `rst` the state field reads reset (0) with the valid flag set, every flag bank reads zero, `irq` and `eng_run` are low.
- R2: The state word (address 0) carries the state in bits [1:0] (reset 0, run 1, pause 3), valid at bit 2, bus-error pending at bit 3 and master ready at bit 4. An accepted write to address 0 clears valid for LAT (default 6 = 3 + 3) consecutive cycles. The requested state then appears with valid set.
- R3: A write to address 0 while valid is low is ignored.
- R4: A requested value of 2 is taken as a request for reset.
- R5: A write of 1 in bit 0 to address 1 at once forces reset with valid set. It clears the operational flags, the error flags, the bus-error latch and `irq`. The interrupt enables are kept.
- R6: Event inputs `ev_op[0..3]` (input service, output service, output count done, input count done) set bits 8..11 of address 2. Writing 1 to a bit clears it. A new event in the same cycle as its clear leaves the bit set.
- R7: `err_set` pulses set bits of address 3 only where the mask 0x7C has ones. Writing 1 to a set bit clears it.
- R8: `irq` is high while any flag bit that is enabled in address 4 is set, or while the bus-error latch is set. Enable bit positions match the flag positions.
- R9: A `bus_err` pulse sets the bus-error latch. Only an accepted state write requesting reset (0 or 2), or R5, clears it.
- R10: Master ready (bit 4) equals valid AND `eng_idle`.
- R11: `eng_run` is high only in the run state with valid set. It is low in pause, in reset and during any transition.
- R12: Register reads return data on `reg_rdata` one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address (0 state, 1 soft reset, 2 events, 3 errors, 4 enables) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| ev_op | input | 4 | Operational event pulses from the engine |
| err_set | input | DW | Core error pulses |
| bus_err | input | 1 | Bus protocol error pulse |
| eng_idle | input | 1 | Engine idle indication |
| eng_run | output | 1 | Engine may run and fetch queued entries |
| irq | output | 1 | Level-high interrupt |

## Verification
The assertions take every input as a synchronous single-cycle sample with no ordering among inputs. Their only assumption is that `rst` is held for at least one edge. Event and error pulses may coincide with clears and soft resets, and the flag assertions allow for that by letting a same-cycle set win. The bench drives all inputs on the falling edge and holds each pulse for exactly one rising edge. It deliberately places a second state write inside a transition, and a soft reset inside a transition, so that the ignore and override paths are exercised.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd3
  } op_state_t;

  localparam int A_STATE = 0;
  localparam int A_SWRST = 1;
  localparam int A_EVENT = 2;
  localparam int A_ERROR = 3;
  localparam int A_IRQEN = 4;
endpackage

// File: rtl/bsc_state_seq.sv
module bsc_state_seq
  import bsc_pkg::*;
#(
  parameter int LAT = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_rst,
  input  logic       req_we,
  input  logic [1:0] req_val,
  output op_state_t  state,
  output logic       valid
);
  localparam int CW = $clog2(LAT + 1);

  op_state_t tgt;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      state <= ST_RESET;
      tgt   <= ST_RESET;
      valid <= 1'b1;
      cnt   <= '0;
    end else if (valid && req_we) begin
      tgt   <= (req_val == 2'd2) ? ST_RESET : op_state_t'(req_val);
      valid <= 1'b0;
      cnt   <= CW'(LAT - 1);
    end else if (!valid) begin
      if (cnt == '0) begin
        state <= tgt;
        valid <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R2: state is frozen and stays invalid until the countdown ends
  p_hold_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!valid && !sw_rst && cnt != '0) |=> ($stable(state) && !valid));
  // R3: requests during a transition do not alter the pending target
  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (!valid && req_we && !sw_rst) |=> $stable(tgt));
  // R4: the undefined code never becomes the current state
  p_no_code2_r4: assert property (@(posedge clk) disable iff (rst)
    state != 2'd2);
  // R5: soft reset lands immediately in a valid reset state
  p_swrst_r5: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (state == ST_RESET && valid));
endmodule

// File: rtl/bsc_flag_bank.sv
module bsc_flag_bank #(
  parameter int DW = 16,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_clr,
  input  logic [DW-1:0] set,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_data,
  output logic [DW-1:0] flags
);
  logic [DW-1:0] clr_vec;
  assign clr_vec = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst || sw_clr) flags <= '0;
    else flags <= ((flags & ~clr_vec) | set) & MASK;
  end

  // R6/R7: an incoming event is never lost, even against a clear
  p_set_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (!sw_clr && |(set & MASK)) |=> ((flags & $past(set & MASK)) == $past(set & MASK)));
  // R7: bits outside the mask never read as set
  p_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (flags & ~MASK) == '0);
  // R6: a one written clears the bit unless a new event arrives
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((flags & $past(clr_data & ~set)) == '0));
endmodule

// File: rtl/bus_state_ctrl.sv
module bus_state_ctrl
  import bsc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int IF_CYC = 3,
  parameter int CORE_CYC = 3,
  parameter logic [DW-1:0] ERR_MASK = 'h7C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [3:0]    ev_op,
  input  logic [DW-1:0] err_set,
  input  logic          bus_err,
  input  logic          eng_idle,
  output logic          eng_run,
  output logic          irq
);
  localparam int LAT = IF_CYC + CORE_CYC;
  localparam logic [DW-1:0] OP_MASK = {{(DW-12){1'b0}}, 12'hF00};
  localparam logic [DW-1:0] EN_MASK = OP_MASK | ERR_MASK;

  logic wr_state, sw_rst, wr_ev, wr_err, wr_en;
  assign wr_state = reg_wr && (reg_addr == AW'(A_STATE));
  assign sw_rst   = reg_wr && (reg_addr == AW'(A_SWRST)) && reg_wdata[0];
  assign wr_ev    = reg_wr && (reg_addr == AW'(A_EVENT));
  assign wr_err   = reg_wr && (reg_addr == AW'(A_ERROR));
  assign wr_en    = reg_wr && (reg_addr == AW'(A_IRQEN));

  op_state_t st;
  logic st_valid;

  bsc_state_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .req_we(wr_state), .req_val(reg_wdata[1:0]),
    .state(st), .valid(st_valid)
  );

  logic [DW-1:0] op_flags, err_flags, irq_en;
  logic [DW-1:0] op_set;
  assign op_set = {{(DW-12){1'b0}}, ev_op, 8'h00};

  bsc_flag_bank #(.DW(DW), .MASK(OP_MASK)) u_ev (
    .clk(clk), .rst(rst), .sw_clr(sw_rst), .set(op_set),
    .clr_we(wr_ev), .clr_data(reg_wdata), .flags(op_flags)
  );

  bsc_flag_bank #(.DW(DW), .MASK(ERR_MASK)) u_err (
    .clk(clk), .rst(rst), .sw_clr(sw_rst), .set(err_set),
    .clr_we(wr_err), .clr_data(reg_wdata), .flags(err_flags)
  );

  logic bus_pend, rst_req_ok;
  assign rst_req_ok = wr_state && st_valid && (reg_wdata[1:0] == 2'd0 || reg_wdata[1:0] == 2'd2);

  always_ff @(posedge clk) begin
    if (rst || sw_rst) bus_pend <= 1'b0;
    else if (bus_err) bus_pend <= 1'b1;
    else if (rst_req_ok) bus_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_en <= '0;
    else if (wr_en) irq_en <= reg_wdata & EN_MASK;
  end

  logic ready;
  assign ready   = st_valid && eng_idle;
  assign eng_run = st_valid && (st == ST_RUN);
  assign irq     = (|(op_flags & irq_en)) || (|(err_flags & irq_en)) || bus_pend;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        AW'(A_STATE): reg_rdata <= {{(DW-5){1'b0}}, ready, bus_pend, st_valid, st};
        AW'(A_EVENT): reg_rdata <= op_flags;
        AW'(A_ERROR): reg_rdata <= err_flags;
        AW'(A_IRQEN): reg_rdata <= irq_en;
        default:      reg_rdata <= '0;
      endcase
    end
  end

  // R5: soft reset drops the interrupt on the next cycle
  p_irq_swrst_r5: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> !irq);
  // R11: pause keeps the engine from fetching
  p_pause_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAUSE) |-> !eng_run);
  // R9: a bus error pulse always raises the interrupt next cycle
  p_buserr_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_err && !sw_rst) |=> irq);
endmodule

// File: tb/bus_state_ctrl_test.sv
module bus_state_ctrl_test;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int LAT = 6;

  logic clk = 0;
  logic rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [3:0] ev_op = '0;
  logic [DW-1:0] err_set = '0;
  logic bus_err = 0, eng_idle = 0;
  logic eng_run, irq;

  int checks = 0;
  int errors = 0;

  always #2ns clk = ~clk;

  bus_state_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_op(ev_op), .err_set(err_set),
    .bus_err(bus_err), .eng_idle(eng_idle), .eng_run(eng_run), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    reg_rd = 1; reg_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(logic [3:0] op, logic [DW-1:0] er, logic be);
    ev_op = op; err_set = er; bus_err = be;
    @(posedge clk); @(negedge clk);
    ev_op = '0; err_set = '0; bus_err = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(0, d); chk("R1 state", d, 16'h0004);
    rd(2, d); chk("R1 events", d, 0);
    rd(3, d); chk("R1 errors", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 eng_run", eng_run, 0);
  endtask

  task automatic t_transition();
    logic [DW-1:0] d;
    int n = 0;
    wr(0, 16'h1);
    for (int i = 0; i < 20; i++) begin
      rd(0, d);
      if (d[2]) break;
      n++;
    end
    chk("R2 invalid cycles", n, LAT);
    chk("R2 run state", d, 16'h0005);
    chk("R11 run", eng_run, 1);
    wr(0, 16'h3);
    chk("R11 transit low", eng_run, 0);
    idle(10);
    rd(0, d); chk("R2 pause state", d, 16'h0007);
    chk("R11 pause", eng_run, 0);
  endtask

  task automatic t_busy();
    logic [DW-1:0] d;
    wr(0, 16'h1);
    wr(0, 16'h3);
    idle(10);
    rd(0, d); chk("R3 ignored write", d, 16'h0005);
  endtask

  task automatic t_undef();
    logic [DW-1:0] d;
    wr(0, 16'h2);
    idle(10);
    rd(0, d); chk("R4 code 2 -> reset", d, 16'h0004);
    chk("R11 reset", eng_run, 0);
  endtask

  task automatic t_ready();
    logic [DW-1:0] d;
    eng_idle = 1;
    rd(0, d); chk("R10 ready", d, 16'h0014);
    wr(0, 16'h1);
    rd(0, d); chk("R10 not ready in transit", d, 16'h0000);
    idle(10);
  endtask

  task automatic t_flags();
    logic [DW-1:0] d;
    pulse(4'b0101, '0, 0);
    rd(2, d); chk("R6 set", d, 16'h0500);
    wr(2, 16'h0100);
    rd(2, d); chk("R6 w1c", d, 16'h0400);
    ev_op = 4'b0001; reg_wr = 1; reg_addr = 3'd2; reg_wdata = 16'h0100;
    @(posedge clk); @(negedge clk);
    ev_op = '0; reg_wr = 0;
    rd(2, d); chk("R6 set wins", d, 16'h0500);
    pulse(4'b1010, '0, 0);
    rd(2, d); chk("R6 all bits", d, 16'h0F00);
    wr(2, 16'hFFFF);
    rd(2, d); chk("R6 clear all", d, 0);
  endtask

  task automatic t_err();
    logic [DW-1:0] d;
    pulse('0, 16'hFFFF, 0);
    rd(3, d); chk("R7 masked", d, 16'h007C);
    wr(3, 16'h0004);
    rd(3, d); chk("R7 w1c", d, 16'h0078);
    wr(3, 16'hFFFF);
    rd(3, d); chk("R7 clear", d, 0);
  endtask

  task automatic t_irq();
    wr(4, 16'h0200);
    pulse(4'b0001, '0, 0);
    chk("R8 disabled flag", irq, 0);
    pulse(4'b0010, '0, 0);
    chk("R8 enabled flag", irq, 1);
    wr(2, 16'h0200);
    chk("R8 cleared", irq, 0);
    wr(4, 16'h0010);
    pulse('0, 16'h0010, 0);
    chk("R8 error irq", irq, 1);
    wr(3, 16'h0010);
    chk("R8 error cleared", irq, 0);
    wr(2, 16'hFFFF);
    wr(4, 16'h0000);
  endtask

  task automatic t_bus();
    logic [DW-1:0] d;
    pulse('0, '0, 1);
    chk("R9 irq", irq, 1);
    rd(0, d); chk("R9 pending bit", d, 16'h001D);
    wr(0, 16'h3);
    idle(10);
    chk("R9 held over pause", irq, 1);
    wr(0, 16'h0);
    chk("R9 cleared by reset request", irq, 0);
    idle(10);
    rd(0, d); chk("R9 state", d, 16'h0014);
  endtask

  task automatic t_swrst();
    logic [DW-1:0] d;
    wr(0, 16'h1);
    idle(10);
    pulse(4'hF, 16'h007C, 1);
    wr(4, 16'h0F7C);
    chk("R8 all pending", irq, 1);
    wr(1, 16'h1);
    chk("R5 irq", irq, 0);
    rd(0, d); chk("R5 state", d, 16'h0014);
    rd(2, d); chk("R5 events", d, 0);
    rd(3, d); chk("R5 errors", d, 0);
    rd(4, d); chk("R5 enables kept", d, 16'h0F7C);
    wr(0, 16'h1);
    wr(1, 16'h1);
    rd(0, d); chk("R5 during transit", d, 16'h0014);
    rd(5, d); chk("R12 unmapped", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_transition();
    t_busy();
    t_undef();
    t_ready();
    t_flags();
    t_err();
    t_irq();
    t_bus();
    t_swrst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule